// File: doc/BRIEF.md
# Divided Module Clock with Two Phase-Shifted Copies

This block builds a module clock for a peripheral from one of several source clocks. Everything runs on one fast system clock. Each source is presented as a one-cycle pulse, `src_edge[i]`, which marks every edge (rising or falling) of that source. So two pulses make one source period. The chosen source is divided first by a power of two and then by a linear factor. The result, `mod_clk`, is a 50 % duty square wave held as a registered level.

Two copies of `mod_clk` are also produced: `out_clk` drives the device and `smp_clk` samples its returning data. Each copy is delayed from `mod_clk` by a whole number of source periods set by a 2-bit code. Code zero gives a half-period shift of the module clock, which is 180 degrees. A nonzero code d gives a delay of d source periods. With a total division N, that is about d·round(360/N) degrees.

A single 32-bit control word holds every setting. It is written through a plain write strobe and is always visible on a read bus.

Top module: `mcg_clkgen`

## Requirements
- R1: The control word keeps only these fields, and every other bit reads back as zero:
  - enable: bit 31
  - source select: bits 25:24
  - sample-phase code: bits 21:20
  - pre-divide exponent p: bits 17:16
  - output-phase code: bits 9:8
  - linear divide m: bits 3:0

  With SEL_W=2 the readback mask is 0x8333_030F.
- R2: A select code below NSRC clocks the divider from `src_edge[code]`. One pulse is one source edge.
- R3: While running, `mod_clk` stays high for N selected source edges and then low for N, where N = (m+1)·2^p.
- R4: After a write that clears the enable bit, all three clock outputs are low from the second clock edge after the write onward.
- R5: A select code of NSRC or above drives all three clock outputs low, even with enable set.
- R6: New m, p and phase codes take effect only at the next rising edge of `mod_clk`. The output period in progress completes with the old values.
- R7: `out_clk` equals `mod_clk` delayed by 2·d selected source edges when the output-phase code d is nonzero, and by N edges (180 degrees) when d is 0.
- R8: `smp_clk` follows the same rule as R7, using the sample-phase code.
- R9: On leaving the idle state, `mod_clk` rises on the first selected source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all sources are enables of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_edge | input | NSRC | One-cycle pulse per edge of each source clock |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word, unused bits zero |
| mod_clk | output | 1 | Divided, gated module clock |
| out_clk | output | 1 | Phase-delayed copy for the device |
| smp_clk | output | 1 | Phase-delayed copy for sampling |

## Verification
The assertions assume that each `src_edge` bit is a synchronous pulse of at most one cycle per source edge. They also assume that the control word changes only through `cfg_we`. The stimulus drives the three sources with fixed, evenly spaced pulse trains, one every 1, 2 and 3 cycles, and updates them and the write port only on the falling edge.

After every enable, the bench waits for at least two full output periods before it measures phase. By then the delay history holds valid samples, and the 180-degree and 2·d relations the tap assertions rely on are already in force.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  // Field layout of the control word
  localparam int EN_BIT  = 31;
  localparam int SEL_LSB = 24;
  localparam int SPH_LSB = 20;
  localparam int P_LSB   = 16;
  localparam int OPH_LSB = 8;
  localparam int M_LSB   = 0;
  localparam int M_W     = 4;
  localparam int P_W     = 2;
  localparam int PH_W    = 2;

  // Largest total division and the counter width that holds it
  localparam int NMAX  = (1 << M_W) << ((1 << P_W) - 1);
  localparam int CNT_W = $clog2(NMAX + 1);
  localparam int PHMAX = 2 * ((1 << PH_W) - 1);
  localparam int HIST  = (NMAX > PHMAX) ? NMAX : PHMAX;
  localparam int IDX_W = $clog2(HIST);

  typedef struct packed {
    logic [M_W-1:0]  m;
    logic [P_W-1:0]  p;
    logic [PH_W-1:0] oph;
    logic [PH_W-1:0] sph;
  } div_cfg_t;

  function automatic logic [CNT_W-1:0] total_div(div_cfg_t c);
    logic [CNT_W-1:0] base;
    base = CNT_W'(c.m) + CNT_W'(1);
    return base << c.p;
  endfunction
endpackage

// File: rtl/mcg_ctrl_reg.sv
module mcg_ctrl_reg
  import mcg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output div_cfg_t          cfg
);
  function automatic logic [31:0] build_mask();
    logic [31:0] k;
    k = '0;
    k[EN_BIT] = 1'b1;
    for (int i = 0; i < SEL_W; i++) k[SEL_LSB+i] = 1'b1;
    for (int i = 0; i < PH_W; i++) begin
      k[SPH_LSB+i] = 1'b1;
      k[OPH_LSB+i] = 1'b1;
    end
    for (int i = 0; i < P_W; i++) k[P_LSB+i] = 1'b1;
    for (int i = 0; i < M_W; i++) k[M_LSB+i] = 1'b1;
    return k;
  endfunction

  localparam logic [31:0] MASK = build_mask();

  logic [31:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata & MASK;
  end

  assign rdata   = word_q;
  assign en      = word_q[EN_BIT];
  assign sel     = word_q[SEL_LSB +: SEL_W];
  assign cfg.m   = word_q[M_LSB +: M_W];
  assign cfg.p   = word_q[P_LSB +: P_W];
  assign cfg.oph = word_q[OPH_LSB +: PH_W];
  assign cfg.sph = word_q[SPH_LSB +: PH_W];

  AST_RDBACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == ($past(wdata) & MASK)); // R1
endmodule

// File: rtl/mcg_src_mux.sv
module mcg_src_mux #(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2
) (
  input  logic [NSRC-1:0]  src_edge,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic             valid
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0] cand;

  for (genvar i = 0; i < NSEL; i++) begin : g_cand
    if (i < NSRC) begin : g_live
      assign cand[i] = src_edge[i];
    end else begin : g_dead
      assign cand[i] = 1'b0;
    end
  end

  assign tick  = cand[sel];
  assign valid = (32'(sel) < NSRC);
endmodule

// File: rtl/mcg_divider.sv
module mcg_divider
  import mcg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            tick,
  input  div_cfg_t        cfg_in,
  output logic            mod_q,
  output logic [HIST-1:0] hist,
  output div_cfg_t        act
);
  logic [CNT_W-1:0] hc;
  logic [CNT_W-1:0] n_act;

  assign n_act = total_div(act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= 1'b0;
      hc    <= '0;
      act   <= '0;
      hist  <= '0;
    end else if (idle) begin
      // Preset so the first selected edge produces a rising edge
      mod_q <= 1'b0;
      hc    <= total_div(cfg_in) - CNT_W'(1);
      act   <= cfg_in;
      hist  <= '0;
    end else if (tick) begin
      hist <= {hist[HIST-2:0], mod_q};
      if (hc == n_act - CNT_W'(1)) begin
        hc    <= '0;
        mod_q <= !mod_q;
        if (!mod_q) act <= cfg_in;  // period boundary: rising edge
      end else begin
        hc <= hc + CNT_W'(1);
      end
    end
  end

  AST_HC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hc < n_act); // R3

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != $past(mod_q)) && !$past(idle) |-> $past(tick)); // R2

  AST_LOAD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) && !$past(idle) |-> (mod_q && !$past(mod_q))); // R6
endmodule

// File: rtl/mcg_phase_tap.sv
module mcg_phase_tap
  import mcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HIST-1:0]  hist,
  input  logic [PH_W-1:0]  code,
  input  logic [CNT_W-1:0] n_act,
  output logic             clk_o
);
  logic [CNT_W:0]   dly;
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (code == '0) dly = {1'b0, n_act};         // half output period
    else            dly = (CNT_W+1)'({code, 1'b0}); // d source periods
    idx   = IDX_W'(dly - (CNT_W+1)'(1));
    clk_o = hist[idx];
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dly >= 1) && (dly <= HIST)); // R7
endmodule

// File: rtl/mcg_clkgen.sv
module mcg_clkgen
  import mcg_pkg::*;
#(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_edge,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            mod_clk,
  output logic            out_clk,
  output logic            smp_clk
);
  logic             en;
  logic [SEL_W-1:0] sel;
  div_cfg_t         cfg_w;
  div_cfg_t         act;
  logic             tick;
  logic             valid;
  logic             idle;
  logic [HIST-1:0]  hist;
  logic [1:0]       taps;

  mcg_ctrl_reg #(.SEL_W(SEL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en(en), .sel(sel), .cfg(cfg_w)
  );

  mcg_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .src_edge(src_edge), .sel(sel), .tick(tick), .valid(valid)
  );

  assign idle = !en || !valid;

  mcg_divider u_div (
    .clk(clk), .rst_n(rst_n), .idle(idle), .tick(tick), .cfg_in(cfg_w),
    .mod_q(mod_clk), .hist(hist), .act(act)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tap
    mcg_phase_tap u_tap (
      .clk(clk), .rst_n(rst_n), .hist(hist),
      .code((g == 0) ? act.oph : act.sph),
      .n_act(total_div(act)), .clk_o(taps[g])
    );
  end

  assign out_clk = taps[0];
  assign smp_clk = taps[1];

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> !mod_clk && !out_clk && !smp_clk); // R4

  AST_NOSRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!valid) |-> !mod_clk && !out_clk && !smp_clk); // R5
endmodule

// File: tb/mcg_clkgen_tb.sv
module mcg_clkgen_tb;
  localparam int NSRC = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_edge = '0;
  logic            cfg_we = 1'b0;
  logic [31:0]     cfg_wdata = '0;
  logic [31:0]     cfg_rdata;
  logic            mod_clk, out_clk, smp_clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit tm [0:8191];
  bit to [0:8191];
  bit ts [0:8191];

  mcg_clkgen #(.NSRC(NSRC), .SEL_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_edge(src_edge), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mod_clk(mod_clk),
    .out_clk(out_clk), .smp_clk(smp_clk)
  );

  always #2.5 clk = ~clk;

  // Source i pulses every (i+1) system cycles
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      src_edge[0] = 1'b1;
      src_edge[1] = (c % 2 == 0);
      src_edge[2] = (c % 3 == 0);
      c++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(int sel, int p, int m, int co, int cs);
    return 32'h8000_0000 | (32'(sel) << 24) | (32'(cs) << 20) |
           (32'(p) << 16) | (32'(co) << 8) | 32'(m);
  endfunction

  task automatic run_cfg(input int sel, input int p, input int m,
                         input int co, input int cs);
    int t, n, per, len, t0, hi, lo, k, ro, rs, dexp, oexp, sexp;
    t = sel + 1;
    n = (m + 1) << p;
    per = 2 * n * t;
    len = 3 * per + 2;
    wr(mk(sel, p, m, co, cs));
    repeat (2 * per) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tm[i] = mod_clk; to[i] = out_clk; ts[i] = smp_clk;
    end
    t0 = -1;
    for (int i = 1; i < len && t0 < 0; i++)
      if (tm[i] && !tm[i-1]) t0 = i;
    hi = 0; k = t0;
    while (k >= 0 && k < len && tm[k]) begin hi++; k++; end
    lo = 0;
    while (k >= 0 && k < len && !tm[k]) begin lo++; k++; end
    chk(hi == n * t, "R2 R3 high run", hi, n * t);
    chk(lo == n * t, "R3 low run", lo, n * t);
    ro = -1; rs = -1;
    for (int i = t0; t0 >= 1 && i < t0 + per; i++) begin
      if (ro < 0 && to[i] && !to[i-1]) ro = i - t0;
      if (rs < 0 && ts[i] && !ts[i-1]) rs = i - t0;
    end
    dexp = (co == 0) ? n : 2 * co;
    oexp = (dexp * t) % per;
    dexp = (cs == 0) ? n : 2 * cs;
    sexp = (dexp * t) % per;
    chk(ro == oexp, "R7 out_clk offset", ro, oexp);
    chk(rs == sexp, "R8 smp_clk offset", rs, sexp);
    wr(32'h0);
  endtask

  initial begin
    int idx;
    bit seen;
    int exp_pat [0:7];
    int mlist [0:4];
    exp_pat = '{1, 0, 0, 0, 0, 1, 0, 1};
    mlist = '{0, 1, 2, 6, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1 reset word", cfg_rdata, 0);
    chk(!mod_clk && !out_clk && !smp_clk, "R4 reset outputs low",
        {mod_clk, out_clk, smp_clk}, 0);

    // R1 masking; all ones also selects code 3 (no source) -> R5
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h8333_030F, "R1 mask all ones", cfg_rdata, 32'h8333_030F);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mod_clk || out_clk || smp_clk) seen = 1;
    end
    chk(!seen, "R5 no source stays low", seen, 0);
    wr(32'h8122_1203);
    chk(cfg_rdata == 32'h8122_0203, "R1 mask mixed", cfg_rdata, 32'h8122_0203);
    wr(32'h0);

    // R9 first rise and R6 boundary change: src0, N=4 then m=0
    wr(mk(0, 0, 3, 1, 1));
    @(negedge clk);
    chk(mod_clk == 1'b1, "R9 first edge rises", mod_clk, 1);
    wr(mk(0, 0, 0, 1, 1));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(mod_clk == exp_pat[i][0], "R6 period completes", mod_clk, exp_pat[i]);
    end

    // R4 disable while running
    wr(32'h0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mod_clk || out_clk || smp_clk) seen = 1;
    end
    chk(!seen, "R4 disable low", seen, 0);

    // Sweep: source, exponent, linear factor, phase codes
    idx = 0;
    for (int s = 0; s < NSRC; s++)
      for (int p = 0; p < 4; p++)
        for (int mi = 0; mi < 5; mi++) begin
          run_cfg(s, p, mlist[mi], idx % 4, (idx / 4) % 4);
          idx++;
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule